// File: doc/BRIEF.md
# DC-Bus Fault Ride-Through Supervisor

This block sequences the operating regime of a battery converter leg and a supercapacitor converter leg that share a DC bus. It reads a stream of digitized bus-voltage samples, each tagged by a valid strobe. From these samples it decides whether both legs run under their standard control loops, or whether the bus has collapsed. When the bus has collapsed, the supercapacitor leg is switched off. The battery leg is then driven from a small fixed current reference that is held through the short. Once the short clears, this current charges the bus capacitance at a steady rate. When the bus reaches a recovery level, the block hands control back to the normal loops without outside help.

The same low-current charging regime is used at power-up to precharge the bus. A short that lasts too long is treated as permanent, and the battery leg is also turned off to limit battery drain. From that state only a restart pulse brings the block back to precharge. The fault level, the recovery level, the timeout and the hold-current code are all run-time inputs. Short glitches are filtered by requiring runs of consecutive samples before the block enters a fault or leaves it.

Top module: `frt_supervisor`

## Requirements
- R1: While reset is asserted and after it is released, the block is in precharge (mode code 0). In that state the battery leg is enabled on the hold current, the supercapacitor leg is off and the inductor-voltage floor clamp is active.
- R2: In precharge, N_RECOV consecutive valid samples at or above `cfg_recover_lvl` move the block to normal control (mode code 1). The new mode is visible after the clock edge that takes the last of those samples.
- R3: In normal control, N_FAULT consecutive valid samples strictly below `cfg_fault_lvl` move the block to fault hold (mode code 2). Any valid sample at or above that level breaks the run.
- R4: A cycle with `sample_vld` low neither advances nor breaks any run or timer, and it causes no mode change except a restart taken out of shutdown.
- R5: In fault hold, N_RECOV consecutive valid samples at or above `cfg_recover_lvl` return the block to normal control.
- R6: In fault hold, each valid sample below `cfg_recover_lvl` advances a timeout count, and samples at or above that level pause it. The block goes to shutdown (mode code 3) on the sample that brings the count to `cfg_timeout` (a value of 0 acts as 1). The count starts from zero on every entry to fault hold.
- R7: In shutdown, both legs are off, the clamp and the current select are inactive, and the block stays there whatever the samples are, until `restart` is high on a clock edge. That edge moves it to precharge.
- R8: `restart` has no effect in any state other than shutdown.
- R9: In normal control, both legs are enabled, `iref_sel` is 0, `hold_iref` is 0 and the clamp is off. In precharge and fault hold, `iref_sel` is 1, `hold_iref` equals `cfg_hold_iref` and `scap_en` is 0.
- R10: Every change of state clears the sample runs. Samples taken before a transition never count toward a run in the new state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_vld | input | 1 | Strobe marking a new bus-voltage sample |
| sample | input | SW | Bus-voltage sample code |
| restart | input | 1 | Leave shutdown and go to precharge |
| cfg_fault_lvl | input | SW | Fault level; samples below it count as collapsed |
| cfg_recover_lvl | input | SW | Recovery level; samples at or above it count as recovered |
| cfg_timeout | input | TW | Samples below recovery allowed in fault hold |
| cfg_hold_iref | input | IW | Hold-current reference code |
| mode | output | 2 | 0 precharge, 1 normal, 2 fault hold, 3 shutdown |
| batt_en | output | 1 | Battery leg switching enable |
| scap_en | output | 1 | Supercapacitor leg switching enable |
| iref_sel | output | 1 | 1 selects the fixed hold current for the battery loop |
| hold_iref | output | IW | Hold-current code while selected, else 0 |
| vl_floor_zero | output | 1 | Clamp the battery inductor-voltage lower limit to zero |

## Verification
The bench breaks collapse and recovery runs with an in-between sample and with invalid cycles. A design that reset its runs on invalid strobes would enter fault hold late, and one that ignored the break would trip on scattered noise. The timeout is driven after a fault hold that ended with the count partly used, so a timer that kept its old count would shut down on the first sample of the next fault. Samples above recovery are placed between sub-threshold ones to show that the timer pauses rather than restarts. Recovery samples are also fed during shutdown just before a restart, so a design that kept runs across transitions would leave precharge too early.

// File: rtl/frt_pkg.sv
package frt_pkg;
  typedef enum logic [1:0] {
    ST_PRECHG = 2'd0,
    ST_NORMAL = 2'd1,
    ST_HOLD   = 2'd2,
    ST_OFF    = 2'd3
  } frt_state_t;
endpackage

// File: rtl/frt_run_qual.sv
module frt_run_qual #(
  parameter int RUN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic vld,
  input  logic hit,
  output logic done
);
  localparam int CW = $clog2(RUN + 1);
  localparam logic [CW-1:0] LAST = CW'(RUN - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | vld;
    cnt_d  = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (vld) begin
      if (!hit) begin
        cnt_d = '0;
      end else if (cnt_q < LAST) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done = vld & hit & (cnt_q >= LAST);
endmodule

// File: rtl/frt_hold_timer.sv
module frt_hold_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          expire
);
  logic [TW-1:0] tcnt_q;
  logic [TW:0]   tnext;

  assign tnext  = {1'b0, tcnt_q} + 1'b1;
  assign expire = run & (tnext >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q <= '0;
    end else if (clr) begin
      tcnt_q <= '0;
    end else if (run && !tnext[TW]) begin
      tcnt_q <= tnext[TW-1:0];
    end
  end
endmodule

// File: rtl/frt_mode_fsm.sv
module frt_mode_fsm
  import frt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       collapse_done,
  input  logic       recover_done,
  input  logic       timeout_hit,
  input  logic       restart,
  output frt_state_t state,
  output logic       change
);
  frt_state_t state_q;
  frt_state_t state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_PRECHG: if (recover_done) state_d = ST_NORMAL;
      ST_NORMAL: if (collapse_done) state_d = ST_HOLD;
      ST_HOLD: begin
        if (recover_done) begin
          state_d = ST_NORMAL;
        end else if (timeout_hit) begin
          state_d = ST_OFF;
        end
      end
      ST_OFF:    if (restart) state_d = ST_PRECHG;
      default:   state_d = ST_PRECHG;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PRECHG;
    end else begin
      state_q <= state_d;
    end
  end

  assign state  = state_q;
  assign change = (state_d != state_q);
endmodule

// File: rtl/frt_supervisor.sv
module frt_supervisor
  import frt_pkg::*;
#(
  parameter int SW      = 12,
  parameter int TW      = 16,
  parameter int IW      = 10,
  parameter int N_FAULT = 3,
  parameter int N_RECOV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_vld,
  input  logic [SW-1:0] sample,
  input  logic          restart,
  input  logic [SW-1:0] cfg_fault_lvl,
  input  logic [SW-1:0] cfg_recover_lvl,
  input  logic [TW-1:0] cfg_timeout,
  input  logic [IW-1:0] cfg_hold_iref,
  output logic [1:0]    mode,
  output logic          batt_en,
  output logic          scap_en,
  output logic          iref_sel,
  output logic [IW-1:0] hold_iref,
  output logic          vl_floor_zero
);
  frt_state_t state;
  logic       change;
  logic       below_fault;
  logic       at_recover;
  logic       collapse_done;
  logic       recover_done;
  logic       timer_run;
  logic       timeout_hit;

  assign below_fault = sample < cfg_fault_lvl;
  assign at_recover  = sample >= cfg_recover_lvl;
  assign timer_run   = (state == ST_HOLD) & sample_vld & ~at_recover;

  frt_run_qual #(.RUN(N_FAULT)) u_collapse (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (change),
    .vld   (sample_vld),
    .hit   (below_fault),
    .done  (collapse_done)
  );

  frt_run_qual #(.RUN(N_RECOV)) u_recover (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (change),
    .vld   (sample_vld),
    .hit   (at_recover),
    .done  (recover_done)
  );

  frt_hold_timer #(.TW(TW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (change),
    .run    (timer_run),
    .limit  (cfg_timeout),
    .expire (timeout_hit)
  );

  frt_mode_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .collapse_done (collapse_done),
    .recover_done  (recover_done),
    .timeout_hit   (timeout_hit),
    .restart       (restart),
    .state         (state),
    .change        (change)
  );

  always_comb begin
    mode          = state;
    batt_en       = 1'b0;
    scap_en       = 1'b0;
    iref_sel      = 1'b0;
    vl_floor_zero = 1'b0;
    unique case (state)
      ST_NORMAL: begin
        batt_en = 1'b1;
        scap_en = 1'b1;
      end
      ST_PRECHG, ST_HOLD: begin
        batt_en       = 1'b1;
        iref_sel      = 1'b1;
        vl_floor_zero = 1'b1;
      end
      default: ;
    endcase
    hold_iref = iref_sel ? cfg_hold_iref : '0;
  end
endmodule

// File: rtl/frt_supervisor_chk.sv
module frt_supervisor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sample_vld,
  input logic       restart,
  input logic [1:0] mode,
  input logic       batt_en,
  input logic       scap_en,
  input logic       iref_sel
);
  // R2
  prechg_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) |=> (mode == 2'd0 || mode == 2'd1));

  // R3
  normal_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1) |=> (mode == 2'd1 || mode == 2'd2));

  // R6
  off_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && $past(mode) != 2'd3) |-> ($past(mode) == 2'd2));

  // R7
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && !restart) |=> (mode == 2'd3));

  // R4
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_vld && mode != 2'd3) |=> $stable(mode));

  // R9
  scap_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iref_sel |-> (!scap_en && batt_en));
endmodule

bind frt_supervisor frt_supervisor_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sample_vld (sample_vld),
  .restart    (restart),
  .mode       (mode),
  .batt_en    (batt_en),
  .scap_en    (scap_en),
  .iref_sel   (iref_sel)
);

// File: tb/tb_frt_supervisor.sv
module tb_frt_supervisor;
  localparam int SW = 12;
  localparam int TW = 16;
  localparam int IW = 10;
  localparam int NF = 3;
  localparam int NR = 4;

  logic          clk;
  logic          rst_n;
  logic          sample_vld;
  logic [SW-1:0] sample;
  logic          restart;
  logic [SW-1:0] cfg_fault_lvl;
  logic [SW-1:0] cfg_recover_lvl;
  logic [TW-1:0] cfg_timeout;
  logic [IW-1:0] cfg_hold_iref;
  logic [1:0]    mode;
  logic          batt_en;
  logic          scap_en;
  logic          iref_sel;
  logic [IW-1:0] hold_iref;
  logic          vl_floor_zero;

  int checks = 0;
  int bad    = 0;
  int m_state, m_brun, m_arun, m_tcnt;

  frt_supervisor #(.SW(SW), .TW(TW), .IW(IW), .N_FAULT(NF), .N_RECOV(NR)) dut (
    .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .sample(sample),
    .restart(restart), .cfg_fault_lvl(cfg_fault_lvl),
    .cfg_recover_lvl(cfg_recover_lvl), .cfg_timeout(cfg_timeout),
    .cfg_hold_iref(cfg_hold_iref), .mode(mode), .batt_en(batt_en),
    .scap_en(scap_en), .iref_sel(iref_sel), .hold_iref(hold_iref),
    .vl_floor_zero(vl_floor_zero)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic cmp_model();
    logic e_b, e_s, e_i, e_z;
    logic [IW-1:0] e_h;
    e_b = (m_state != 3);
    e_s = (m_state == 1);
    e_i = (m_state == 0 || m_state == 2);
    e_z = e_i;
    e_h = e_i ? cfg_hold_iref : '0;
    checks++;
    if (mode != 2'(m_state)) begin
      bad++;
      $display("FAIL R10 state sequence: mode=%0d expected %0d", mode, m_state);
    end
    checks++;
    if ({batt_en, scap_en, iref_sel, vl_floor_zero} != {e_b, e_s, e_i, e_z}
        || hold_iref != e_h) begin
      bad++;
      $display("FAIL R9 outputs: b/s/i/z=%b%b%b%b h=%0d expected %b%b%b%b h=%0d",
               batt_en, scap_en, iref_sel, vl_floor_zero, hold_iref,
               e_b, e_s, e_i, e_z, e_h);
    end
  endtask

  task automatic step(input logic v, input int s, input logic rs);
    logic below, above, brec;
    int nxt;
    @(negedge clk);
    sample_vld = v;
    sample     = SW'(s);
    restart    = rs;
    @(posedge clk);
    below = v && (s < int'(cfg_fault_lvl));
    above = v && (s >= int'(cfg_recover_lvl));
    brec  = v && (s < int'(cfg_recover_lvl));
    nxt   = m_state;
    case (m_state)
      0: if (above && m_arun + 1 >= NR) nxt = 1;
      1: if (below && m_brun + 1 >= NF) nxt = 2;
      2: begin
        if (above && m_arun + 1 >= NR) nxt = 1;
        else if (brec && m_tcnt + 1 >= int'(cfg_timeout)) nxt = 3;
      end
      default: if (rs) nxt = 0;
    endcase
    if (nxt != m_state) begin
      m_brun = 0; m_arun = 0; m_tcnt = 0;
    end else begin
      if (v) begin
        m_brun = below ? ((m_brun + 1 > NF) ? NF : m_brun + 1) : 0;
        m_arun = above ? ((m_arun + 1 > NR) ? NR : m_arun + 1) : 0;
      end
      if (m_state == 2 && brec) m_tcnt++;
    end
    m_state = nxt;
    #1;
    cmp_model();
  endtask

  task automatic expect_mode(input int exp, input string tag);
    checks++;
    if (mode != 2'(exp)) begin
      bad++;
      $display("FAIL %s: mode=%0d expected %0d", tag, mode, exp);
    end
  endtask

  task automatic feed(input int n, input int s);
    for (int i = 0; i < n; i++) step(1'b1, s, 1'b0);
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sample_vld = 1'b0; sample = '0; restart = 1'b0;
    cfg_fault_lvl = 12'd30; cfg_recover_lvl = 12'd900;
    cfg_timeout = 16'd5; cfg_hold_iref = 10'd37;
    m_state = 0; m_brun = 0; m_arun = 0; m_tcnt = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    expect_mode(0, "R1 reset");
    cmp_model();
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 0, 1'b0);
    expect_mode(0, "R1 after release");

    // R2 with R4: invalid cycle inside the recovery run
    feed(3, 1000);
    step(1'b0, 5, 1'b0);
    expect_mode(0, "R4 invalid cycle holds run");
    feed(1, 1000);
    expect_mode(1, "R2 precharge to normal");

    // R3: broken run, then invalid cycle inside a run
    feed(2, 10);
    feed(1, 30);
    feed(2, 10);
    expect_mode(1, "R3 run broken at fault level");
    step(1'b0, 0, 1'b0);
    feed(1, 10);
    expect_mode(2, "R3 normal to fault hold");

    // R8: restart outside shutdown
    step(1'b1, 10, 1'b1);
    expect_mode(2, "R8 restart ignored in fault hold");

    // R6 pause and R5 recovery
    feed(2, 10);
    feed(2, 950);
    feed(1, 10);
    expect_mode(2, "R6 timer paused by high samples");
    feed(4, 950);
    expect_mode(1, "R5 fault hold to normal");

    // R6: timer cleared on entry, expires after 5 low samples
    feed(3, 5);
    expect_mode(2, "R6 re-entry");
    feed(4, 5);
    expect_mode(2, "R6 timer restarted on entry");
    feed(1, 5);
    expect_mode(3, "R6 timeout to shutdown");

    // R7 and R10
    feed(5, 1000);
    expect_mode(3, "R7 shutdown holds");
    step(1'b1, 1000, 1'b1);
    expect_mode(0, "R7 restart to precharge");
    feed(1, 1000);
    expect_mode(0, "R10 run cleared by transition");
    feed(3, 1000);
    expect_mode(1, "R2 recovery after restart");

    // R6: timeout value 0 acts as 1
    cfg_timeout = 16'd0;
    feed(3, 0);
    expect_mode(2, "R3 second collapse");
    feed(1, 0);
    expect_mode(3, "R6 zero timeout");
    step(1'b0, 0, 1'b1);
    expect_mode(0, "R7 restart with invalid sample");
    cfg_hold_iref = 10'd500;
    step(1'b0, 0, 1'b0);
    checks++;
    if (hold_iref != 10'd500) begin
      bad++;
      $display("FAIL R9 hold_iref=%0d expected 500", hold_iref);
    end

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule